// File: doc/BRIEF.md
# RGB-to-YUV Output Color Matrix

This block sits at the end of a display compositor and converts every pixel of the blended 8-bit RGB stream into 8-bit YUV. Each output channel is a weighted sum of the three input components plus a constant. The block holds the twelve matrix terms in registers that software writes through a small indexed write port. An enable input selects between the converted result and an unchanged copy of the input pixel. The stream has no back-pressure: one pixel may arrive on every clock, and it is qualified by a valid bit.

The matrix is double-buffered. Writes land in a pending copy, and the copy in use is replaced only on a frame-start pulse. A reprogramming sequence therefore never changes the colours in the middle of a picture. After reset both copies hold a standard-definition studio-range set, so the block produces usable YUV before any write. Clearing the enable bypasses the arithmetic and keeps all programmed terms.

Top module: `rgb_yuv_matrix`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_vld is low. After reset, both the pending and the in-use set hold the default terms. Row Y is 0x107, 0x204, 0x064, constant 0x108. Row U is 0x3F69, 0x3ED6, 0x1C1, constant 0x808. Row V is 0x1C1, 0x3E88, 0x3FB8, constant 0x808.
- R2: With cvt_en high, each output channel equals floor(cR·R + cG·G + cB·B + k), saturated to 0..255, using that channel's row of the in-use set.
- R3: Index 4·row + n selects the multiplier for input n (0 = R, 1 = G, 2 = B) of a row, and index 4·row + 3 selects the row's constant. Row 0 is Y, row 1 is U and row 2 is V. A multiplier is a 14-bit two's-complement value divided by 1024. A constant is a 14-bit unsigned value divided by 16.
- R4: A negative sum gives 0 and a sum of 256 or more gives 255. Fractional parts are dropped toward minus infinity.
- R5: out_vld equals pix_vld as sampled three rising edges earlier. The result for a pixel sampled on edge k appears after edge k+2.
- R6: With cvt_en low when the pixel is sampled, out_y, out_u and out_v equal R, G and B with the same three-cycle latency.
- R7: Clearing cvt_en and setting it again, with no writes in between, gives the same conversion as before.
- R8: A write changes only the pending set. The in-use set takes the whole pending set on the edge where frame_start is high and stays unchanged on every other edge. A pixel sampled on that same edge still uses the previous set.
- R9: Writes with cfg_idx 12 to 15 change no term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvt_en | input | 1 | 1 = convert, 0 = pass RGB through |
| frame_start | input | 1 | Pulse that copies the pending set into use |
| cfg_we | input | 1 | Term write strobe |
| cfg_idx | input | 4 | Term index 0 to 11 |
| cfg_data | input | 14 | Term value |
| pix_vld | input | 1 | Input pixel valid |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| out_vld | output | 1 | Output pixel valid |
| out_y | output | 8 | Luma, or red when bypassed |
| out_u | output | 8 | Blue-difference chroma, or green when bypassed |
| out_v | output | 8 | Red-difference chroma, or blue when bypassed |

## Verification
The bench builds the block with its default parameters: 8-bit components, 14-bit terms, 10 multiplier fraction bits and 4 constant fraction bits. At these widths the most positive and most negative multipliers, together with the largest constant, drive both ends of the saturation. The 4-bit index also leaves four unused codes that random writes reach often. Random pixels, enable toggles, term writes and frame starts run alongside directed term sets: identity rows that expose the field encoding, extreme rows that force clamping, and writes placed right before and on a frame start.

// File: rtl/rgbyuv_pkg.sv
package rgbyuv_pkg;

    localparam int NUM_ROWS  = 3;
    localparam int ROW_TERMS = 4;
    localparam int NUM_COEF  = NUM_ROWS * ROW_TERMS;

    // Power-on matrix: studio-range conversion, multipliers Q3.10, constants Q10.4
    function automatic logic [13:0] default_coef(input int idx);
        case (idx)
            0:       return 14'h0107;
            1:       return 14'h0204;
            2:       return 14'h0064;
            3:       return 14'h0108;
            4:       return 14'h3F69;
            5:       return 14'h3ED6;
            6:       return 14'h01C1;
            7:       return 14'h0808;
            8:       return 14'h01C1;
            9:       return 14'h3E88;
            10:      return 14'h3FB8;
            11:      return 14'h0808;
            default: return 14'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rgbyuv_coef_bank.sv
module rgbyuv_coef_bank
    import rgbyuv_pkg::*;
#(
    parameter int COEF_W = 14,
    parameter int IDX_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [COEF_W-1:0]                wr_data,
    input  logic                             frame_start,
    output logic [NUM_COEF-1:0][COEF_W-1:0]  active
);

    typedef struct packed {
        logic [NUM_COEF-1:0][COEF_W-1:0] pending;
        logic [NUM_COEF-1:0][COEF_W-1:0] inuse;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic bank_t bank_init();
        bank_t rv;
        for (int i = 0; i < NUM_COEF; i++) begin
            rv.pending[i] = COEF_W'(default_coef(i));
            rv.inuse[i]   = COEF_W'(default_coef(i));
        end
        return rv;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (frame_start) begin
            bank_d.inuse = bank_q.pending;
        end
        if (wr_en && (wr_idx < IDX_W'(NUM_COEF))) begin
            bank_d.pending[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= bank_init();
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active = bank_q.inuse;

endmodule

// File: rtl/rgbyuv_row_mac.sv
module rgbyuv_row_mac #(
    parameter int PIX_W    = 8,
    parameter int COEF_W   = 14,
    parameter int MUL_FRAC = 10,
    parameter int OFS_FRAC = 4,
    parameter int SUM_W    = COEF_W + PIX_W + 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0][COEF_W-1:0] coef,
    input  logic [2:0][PIX_W-1:0]  pix,
    output logic [SUM_W-1:0]       sum_q
);

    localparam int PROD_W    = COEF_W + PIX_W + 1;
    localparam int OFS_SHIFT = MUL_FRAC - OFS_FRAC;

    typedef struct packed {
        logic [2:0][PROD_W-1:0] prod;
        logic [COEF_W-1:0]      ofs;
        logic [SUM_W-1:0]       sum;
    } mac_t;

    mac_t mac_d, mac_q;

    always_comb begin
        logic signed [PROD_W-1:0] c_ext;
        logic signed [PROD_W-1:0] p_ext;
        logic signed [SUM_W-1:0]  acc;
        mac_d = mac_q;
        // stage 1: three signed products and the row constant
        for (int i = 0; i < 3; i++) begin
            c_ext = PROD_W'($signed(coef[i]));
            p_ext = $signed(PROD_W'(pix[i]));
            mac_d.prod[i] = c_ext * p_ext;
        end
        mac_d.ofs = coef[3];
        // stage 2: sum aligned to the multiplier fraction
        acc = '0;
        for (int i = 0; i < 3; i++) begin
            acc = acc + SUM_W'($signed(mac_q.prod[i]));
        end
        acc = acc + $signed(SUM_W'(mac_q.ofs) << OFS_SHIFT);
        mac_d.sum = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign sum_q = mac_q.sum;

endmodule

// File: rtl/rgb_yuv_matrix.sv
module rgb_yuv_matrix
    import rgbyuv_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int COEF_W   = 14,
    parameter int MUL_FRAC = 10,
    parameter int OFS_FRAC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cvt_en,
    input  logic              frame_start,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_idx,
    input  logic [COEF_W-1:0] cfg_data,
    input  logic              pix_vld,
    input  logic [PIX_W-1:0]  pix_r,
    input  logic [PIX_W-1:0]  pix_g,
    input  logic [PIX_W-1:0]  pix_b,
    output logic              out_vld,
    output logic [PIX_W-1:0]  out_y,
    output logic [PIX_W-1:0]  out_u,
    output logic [PIX_W-1:0]  out_v
);

    localparam int IDX_W = 4;
    localparam int SUM_W = COEF_W + PIX_W + 3;
    localparam int INT_W = SUM_W - MUL_FRAC;

    typedef struct packed {
        logic                   v1;
        logic                   e1;
        logic [2:0][PIX_W-1:0]  px1;
        logic                   v2;
        logic                   e2;
        logic [2:0][PIX_W-1:0]  px2;
        logic                   v3;
        logic [2:0][PIX_W-1:0]  o3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [NUM_COEF-1:0][COEF_W-1:0] coef_active;
    logic [2:0][PIX_W-1:0]           pix_in;
    logic [2:0][SUM_W-1:0]           row_sum;

    assign pix_in = {pix_b, pix_g, pix_r};

    rgbyuv_coef_bank #(
        .COEF_W (COEF_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_idx      (cfg_idx),
        .wr_data     (cfg_data),
        .frame_start (frame_start),
        .active      (coef_active)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        rgbyuv_row_mac #(
            .PIX_W    (PIX_W),
            .COEF_W   (COEF_W),
            .MUL_FRAC (MUL_FRAC),
            .OFS_FRAC (OFS_FRAC),
            .SUM_W    (SUM_W)
        ) u_mac (
            .clk   (clk),
            .rst_n (rst_n),
            .coef  (coef_active[ROW_TERMS*r +: ROW_TERMS]),
            .pix   (pix_in),
            .sum_q (row_sum[r])
        );
    end

    // floor to integer, then clamp to the pixel range
    function automatic logic [PIX_W-1:0] saturate(input logic [SUM_W-1:0] s);
        logic [INT_W-1:0] ip;
        ip = s[SUM_W-1:MUL_FRAC];
        if (ip[INT_W-1]) begin
            return '0;
        end else if (|ip[INT_W-2:PIX_W]) begin
            return '1;
        end else begin
            return ip[PIX_W-1:0];
        end
    endfunction

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.v1  = pix_vld;
        pipe_d.e1  = cvt_en;
        pipe_d.px1 = pix_in;
        pipe_d.v2  = pipe_q.v1;
        pipe_d.e2  = pipe_q.e1;
        pipe_d.px2 = pipe_q.px1;
        pipe_d.v3  = pipe_q.v2;
        for (int r = 0; r < NUM_ROWS; r++) begin
            pipe_d.o3[r] = pipe_q.e2 ? saturate(row_sum[r]) : pipe_q.px2[r];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_vld = pipe_q.v3;
    assign out_y   = pipe_q.o3[0];
    assign out_u   = pipe_q.o3[1];
    assign out_v   = pipe_q.o3[2];

endmodule

// File: rtl/rgbyuv_checker.sv
module rgbyuv_checker #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 14,
    parameter int NCOEF  = 12
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cvt_en,
    input logic                         frame_start,
    input logic                         pix_vld,
    input logic [PIX_W-1:0]             pix_r,
    input logic [PIX_W-1:0]             pix_g,
    input logic [PIX_W-1:0]             pix_b,
    input logic                         out_vld,
    input logic [PIX_W-1:0]             out_y,
    input logic [PIX_W-1:0]             out_u,
    input logic [PIX_W-1:0]             out_v,
    input logic [NCOEF-1:0][COEF_W-1:0] coef_active
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> !out_vld);

    assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_vld == $past(pix_vld, 3)));

    assert_bypass_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(pix_vld, 3) && !$past(cvt_en, 3)) |->
        (out_y == $past(pix_r, 3) && out_u == $past(pix_g, 3) && out_v == $past(pix_b, 3)));

    assert_hold_midframe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !$past(frame_start)) |-> $stable(coef_active));

endmodule

bind rgb_yuv_matrix rgbyuv_checker #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .NCOEF  (12)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cvt_en      (cvt_en),
    .frame_start (frame_start),
    .pix_vld     (pix_vld),
    .pix_r       (pix_r),
    .pix_g       (pix_g),
    .pix_b       (pix_b),
    .out_vld     (out_vld),
    .out_y       (out_y),
    .out_u       (out_u),
    .out_v       (out_v),
    .coef_active (coef_active)
);

// File: tb/rgb_yuv_matrix_tb.sv
`timescale 1ns/1ps
module rgb_yuv_matrix_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cvt_en = 1'b0;
    logic        frame_start = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [13:0] cfg_data = '0;
    logic        pix_vld = 1'b0;
    logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_vld;
    logic [7:0]  out_y, out_u, out_v;

    always #2.5 clk = ~clk;

    rgb_yuv_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .cvt_en(cvt_en), .frame_start(frame_start),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .pix_vld(pix_vld), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_vld(out_vld), .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_pend[12];
    int m_use[12];

    bit    e_vld[3];
    int    e_y[3], e_u[3], e_v[3];
    string e_tag[3];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int sx(input int c);
        return (c >= 8192) ? c - 16384 : c;
    endfunction

    // R2 R3 R4 reference: signed Q.10 multipliers, unsigned Q.4 constant, floor, clamp
    function automatic int chan(input int row, input int r, input int g, input int b);
        int acc;
        int q;
        acc = sx(m_use[4*row]) * r + sx(m_use[4*row+1]) * g + sx(m_use[4*row+2]) * b
              + m_use[4*row+3] * 64;
        q = acc >>> 10;
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return q;
    endfunction

    task automatic step(input bit v, input int r, input int g, input int b,
                        input bit en, input bit fs, input bit we, input int idx,
                        input int data, input string tag);
        bit    nv;
        int    ny, nu, nvv;
        pix_vld = v; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
        cvt_en = en; frame_start = fs; cfg_we = we;
        cfg_idx = 4'(idx); cfg_data = 14'(data);
        nv = v;
        if (en) begin
            ny = chan(0, r, g, b); nu = chan(1, r, g, b); nvv = chan(2, r, g, b);
        end else begin
            ny = r; nu = g; nvv = b;
        end
        if (fs) for (int i = 0; i < 12; i++) m_use[i] = m_pend[i];
        if (we && idx < 12) m_pend[idx] = data;
        @(posedge clk);
        for (int i = 2; i > 0; i--) begin
            e_vld[i] = e_vld[i-1]; e_y[i] = e_y[i-1]; e_u[i] = e_u[i-1];
            e_v[i] = e_v[i-1]; e_tag[i] = e_tag[i-1];
        end
        e_vld[0] = nv; e_y[0] = ny; e_u[0] = nu; e_v[0] = nvv; e_tag[0] = tag;
        @(negedge clk);
        chk(out_vld == e_vld[2], "R5", "out_vld", int'(out_vld), int'(e_vld[2]));
        if (e_vld[2]) begin
            chk(out_y == 8'(e_y[2]), e_tag[2], "out_y", int'(out_y), e_y[2]);
            chk(out_u == 8'(e_u[2]), e_tag[2], "out_u", int'(out_u), e_u[2]);
            chk(out_v == 8'(e_v[2]), e_tag[2], "out_v", int'(out_v), e_v[2]);
        end
    endtask

    task automatic pix(input int r, input int g, input int b, input bit en, input string tag);
        step(1'b1, r, g, b, en, 1'b0, 1'b0, 0, 0, tag);
    endtask

    task automatic wr(input int idx, input int data);
        step(1'b0, 0, 0, 0, 1'b1, 1'b0, 1'b1, idx, data, "R3");
    endtask

    task automatic fstart();
        step(1'b0, 0, 0, 0, 1'b1, 1'b1, 1'b0, 0, 0, "R8");
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0, "R5");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        bit en_r;
        seed = $urandom(32'h5eed_0a17);
        for (int i = 0; i < 12; i++) begin
            m_pend[i] = int'(rgbyuv_pkg::default_coef(i));
            m_use[i]  = m_pend[i];
        end
        for (int i = 0; i < 3; i++) begin
            e_vld[i] = 0; e_y[i] = 0; e_u[i] = 0; e_v[i] = 0; e_tag[i] = "R5";
        end

        // R1: idle during reset
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R1", "out_vld in reset", int'(out_vld), 0);
        rst_n = 1'b1;

        // R1 R2: default set in use without any write
        pix(255, 255, 255, 1'b1, "R1");
        pix(0, 0, 0, 1'b1, "R1");
        pix(255, 0, 0, 1'b1, "R2");
        pix(0, 255, 0, 1'b1, "R2");
        pix(16, 128, 240, 1'b1, "R2");
        flush();

        // R6 bypass, then R7 re-enable with the same pixels
        pix(12, 200, 77, 1'b0, "R6");
        pix(255, 1, 128, 1'b0, "R6");
        pix(12, 200, 77, 1'b1, "R7");
        pix(255, 1, 128, 1'b1, "R7");
        flush();

        // R3 identity rows written but not yet in use: R8 expects old results
        wr(0, 14'h0400); wr(1, 0); wr(2, 0); wr(3, 0);
        wr(4, 0); wr(5, 14'h0400); wr(6, 0); wr(7, 14'h0010);
        wr(8, 0); wr(9, 0); wr(10, 14'h3C00); wr(11, 14'h0FF0);
        pix(90, 40, 200, 1'b1, "R8");
        // pixel on the frame-start edge still uses the previous set (R8)
        step(1'b1, 90, 40, 200, 1'b1, 1'b1, 1'b0, 0, 0, "R8");
        pix(90, 40, 200, 1'b1, "R3");
        pix(7, 255, 0, 1'b1, "R3");
        flush();

        // R9 unused indices change nothing
        for (int i = 12; i < 16; i++) step(1'b0, 0, 0, 0, 1'b1, 1'b0, 1'b1, i, 14'h1555, "R9");
        fstart();
        pix(90, 40, 200, 1'b1, "R9");
        pix(3, 9, 27, 1'b1, "R9");
        flush();

        // R4 saturation both ends, floor of a positive fraction
        wr(0, 14'h1FFF); wr(1, 14'h1FFF); wr(2, 14'h1FFF); wr(3, 14'h3FFF);
        wr(4, 14'h2000); wr(5, 14'h2000); wr(6, 14'h2000); wr(7, 0);
        wr(8, 14'h0400); wr(9, 0); wr(10, 0); wr(11, 14'h0008);
        fstart();
        pix(0, 0, 0, 1'b1, "R4");
        pix(255, 255, 255, 1'b1, "R4");
        pix(1, 0, 0, 1'b1, "R4");
        pix(200, 3, 3, 1'b1, "R4");
        flush();

        // random mix
        en_r = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            bit v, fs, we;
            if ($urandom_range(39) == 0) en_r = ~en_r;
            v  = ($urandom_range(3) != 0);
            fs = ((n % 64) == 63);
            we = ($urandom_range(7) == 0);
            step(v, $urandom_range(255), $urandom_range(255), $urandom_range(255),
                 en_r, fs, we, $urandom_range(15), $urandom_range(16383),
                 en_r ? "R2" : "R6");
        end
        flush();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule